// File: doc/BRIEF.md
# Timebase Load Controller

This block is the per-thread time facility that owns a 64-bit timebase and takes it through the handshake that loads it from a chip-level time-of-day source. Software talks to it through one 64-bit mode register. It writes step settings and command bits, and it reads back the configuration, the pending commands, the status flags and an encoded state field.

A load follows a fixed order. Software first sets the load-mode command. The block leaves its reset state and becomes ready for a new value on the next step boundary; a watchdog catches the case where that boundary never arrives. Software then sets the move command. The block waits for the next sync boundary pulse and then accepts one transferred time-of-day value. From that point it counts. The hardware clears each command bit when its step is complete. A pending time-of-day interrupt blocks the move command.

Top module: `timebase_loader`

Register layout (bit 0 is the least significant bit):

| Bits | Meaning |
|------|---------|
| [3:0] | max-cycles-between-steps setting, held for software |
| [7:4] | clocks per step N, where the value 0 is treated as 1 |
| [11:8] | sync-bit select, held for software |
| [14:12] | reserved, always read as 0 |
| [15] | enable |
| [16] | load-mode command |
| [18] | move command |
| [51] | time-of-day interrupt pending, cleared by writing 1 |
| [54] | load-mode timeout |
| [62:60] | state: 0 reset, 1 not-set, 2 sync-wait, 3 get-tod, 4 running, 7 error |

## Requirements
- R1: After reset, the mode register reads all zeros, the state field is 0 (reset) and the timebase is 0.
- R2: A write stores bits [15:0] of the write data, with bits [14:12] forced to 0, and these bits read back unchanged. The state field at bits [62:60] only ever holds 0, 1, 2, 3, 4 or 7.
- R3: A write with bit 15 = 1 and bit 16 = 1 in state reset sets the load command, and bit 16 reads 1 while the command is pending. On the N-th clock edge after that write, the state becomes 1 (not-set) and bit 16 clears.
- R4: If the load command has not completed within LOAD_TIMEOUT clock edges (default 8), the state becomes 7 (error), bit 54 sets and bit 16 clears. N = LOAD_TIMEOUT still succeeds.
- R5: A pulse on todErr sets bit 51. Writing 1 to bit 51 clears it. While bit 51 is set, the move command is ignored.
- R6: A write with bits 15 and 18 set, in state not-set with bit 51 clear, moves the state to 2 (sync-wait) and sets bit 18. A syncPulse in sync-wait moves the state to 3 (get-tod) on that edge. A syncPulse in any other state has no effect.
- R7: todValid in get-tod loads todValue into the timebase on that edge, sets the state to 4 (running) and clears bit 18. todValid in any other state is ignored.
- R8: In running, the timebase increments by 1 once every N clocks and wraps from all ones to 0. In every other state it holds its value.
- R9: Any write with bit 15 = 0 returns the state to reset and clears bits 16, 18 and 54.
- R10: A load command written outside state reset, or a move command written outside state not-set, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| regWrEn | input | 1 | mode register write strobe |
| regWrData | input | 64 | mode register write data |
| regRdData | output | 64 | live mode register contents |
| syncPulse | input | 1 | sync boundary pulse |
| todValid | input | 1 | time-of-day transfer valid |
| todValue | input | 64 | transferred time-of-day value |
| todErr | input | 1 | step or oscillator error from the time-of-day logic |
| timebase | output | 64 | current timebase value |

## Verification
The clocks-per-step field is swept over all 16 codes with the load command. This separates the cases that complete from those that trip the watchdog, and the codes 8 and 9 pin down the exact boundary. Two codes are also timed edge by edge. The full load handshake is repeated with N from 1 to 6, each over a window of 12·N clocks. Only a count period of exactly N yields exactly 12 increments over every one of those windows. Commands, sync pulses and transfers are also sent in the wrong state, and a pending interrupt is raised before a move. These show that each gate blocks only what it should. Loading all ones and stepping once checks the wrap to 0.

// File: rtl/timebase_loader_pkg.sv
package timebase_loader_pkg;

  localparam int REG_W    = 64;
  localparam int CFG_W    = 16;
  localparam int FIELD_W  = 4;
  localparam int MAXC_LSB = 0;
  localparam int CLK_LSB  = 4;
  localparam int SYNC_LSB = 8;
  localparam int EN_BIT   = 15;
  localparam int LOAD_BIT = 16;
  localparam int MOVE_BIT = 18;
  localparam int INTR_BIT = 51;
  localparam int TOUT_BIT = 54;
  localparam int ST_LSB   = 60;
  localparam int ST_W     = 3;
  localparam logic [CFG_W-1:0] CFG_MASK = 16'h8FFF;

  typedef enum logic [ST_W-1:0] {
    ST_RESET     = 3'd0,
    ST_NOT_SET   = 3'd1,
    ST_SYNC_WAIT = 3'd2,
    ST_GET_TOD   = 3'd3,
    ST_RUNNING   = 3'd4,
    ST_ERROR     = 3'd7
  } tbState_e;

  typedef struct packed {
    logic loadTb;
    logic countEn;
  } dpStrobe_t;

endpackage

// File: rtl/timebase_loader_ctrl.sv
module timebase_loader_ctrl
  import timebase_loader_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      wrEnable,
  input  logic      wrLoad,
  input  logic      wrMove,
  input  logic      wrIntrClr,
  input  logic      stepTick,
  input  logic      syncPulse,
  input  logic      todValid,
  input  logic      todErr,
  output tbState_e  stateQ,
  output logic      loadCmdQ,
  output logic      moveCmdQ,
  output logic      intrQ,
  output logic      timeoutQ,
  output dpStrobe_t strobe
);

  localparam int WD_W = (LOAD_TIMEOUT > 1) ? $clog2(LOAD_TIMEOUT) : 1;
  localparam logic [WD_W-1:0] WD_LIMIT = WD_W'(LOAD_TIMEOUT - 1);

  tbState_e        stateD;
  logic            loadCmdD, moveCmdD, intrD, timeoutD;
  logic [WD_W-1:0] wdQ, wdD;
  logic            abortWr, cmdWr;

  assign abortWr = regWrEn & ~wrEnable;
  assign cmdWr   = regWrEn & wrEnable;

  always_comb begin
    stateD        = stateQ;
    loadCmdD      = loadCmdQ;
    moveCmdD      = moveCmdQ;
    timeoutD      = timeoutQ;
    wdD           = wdQ;
    strobe.loadTb = 1'b0;
    if (abortWr) begin
      stateD   = ST_RESET;
      loadCmdD = 1'b0;
      moveCmdD = 1'b0;
      timeoutD = 1'b0;
      wdD      = '0;
    end else begin
      unique case (stateQ)
        ST_RESET: begin
          if (loadCmdQ) begin
            if (stepTick) begin
              stateD   = ST_NOT_SET;
              loadCmdD = 1'b0;
            end else if (wdQ == WD_LIMIT) begin
              stateD   = ST_ERROR;
              timeoutD = 1'b1;
              loadCmdD = 1'b0;
            end else begin
              wdD = wdQ + 1'b1;
            end
          end else if (cmdWr && wrLoad) begin
            loadCmdD = 1'b1;
            wdD      = '0;
          end
        end
        ST_NOT_SET: begin
          if (cmdWr && wrMove && !intrQ) begin
            moveCmdD = 1'b1;
            stateD   = ST_SYNC_WAIT;
          end
        end
        ST_SYNC_WAIT: begin
          if (syncPulse) stateD = ST_GET_TOD;
        end
        ST_GET_TOD: begin
          if (todValid) begin
            stateD        = ST_RUNNING;
            moveCmdD      = 1'b0;
            strobe.loadTb = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (todErr)                   intrD = 1'b1;
    else if (regWrEn && wrIntrClr) intrD = 1'b0;
    else                          intrD = intrQ;
    strobe.countEn = (stateQ == ST_RUNNING) && stepTick && !abortWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_RESET;
      loadCmdQ <= 1'b0;
      moveCmdQ <= 1'b0;
      intrQ    <= 1'b0;
      timeoutQ <= 1'b0;
      wdQ      <= '0;
    end else begin
      stateQ   <= stateD;
      loadCmdQ <= loadCmdD;
      moveCmdQ <= moveCmdD;
      intrQ    <= intrD;
      timeoutQ <= timeoutD;
      wdQ      <= wdD;
    end
  end

endmodule

// File: rtl/timebase_loader_dp.sv
module timebase_loader_dp
  import timebase_loader_pkg::*;
#(
  parameter int TB_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] cfgIn,
  input  dpStrobe_t        strobe,
  input  logic [TB_W-1:0]  todValue,
  output logic [CFG_W-1:0] cfgQ,
  output logic             stepTick,
  output logic [TB_W-1:0]  timebase
);

  logic [FIELD_W-1:0] clkField, period, stepCnt;

  assign clkField = cfgQ[CLK_LSB +: FIELD_W];
  assign period   = (clkField == '0) ? FIELD_W'(1) : clkField;
  assign stepTick = (stepCnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      stepCnt <= '0;
    end else if (regWrEn) begin
      cfgQ    <= cfgIn & CFG_MASK;
      stepCnt <= '0;
    end else if (stepTick) begin
      stepCnt <= '0;
    end else begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               timebase <= '0;
    else if (strobe.loadTb)  timebase <= todValue;
    else if (strobe.countEn) timebase <= timebase + TB_W'(1);
  end

endmodule

// File: rtl/timebase_loader.sv
module timebase_loader
  import timebase_loader_pkg::*;
#(
  parameter int TB_W         = 64,
  parameter int LOAD_TIMEOUT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             syncPulse,
  input  logic             todValid,
  input  logic [TB_W-1:0]  todValue,
  input  logic             todErr,
  output logic [TB_W-1:0]  timebase
);

  tbState_e         stateQ;
  logic             loadCmdQ, moveCmdQ, intrQ, timeoutQ, stepTick;
  logic [CFG_W-1:0] cfgQ;
  dpStrobe_t        strobe;

  timebase_loader_ctrl #(.LOAD_TIMEOUT(LOAD_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .wrEnable(regWrData[EN_BIT]), .wrLoad(regWrData[LOAD_BIT]),
    .wrMove(regWrData[MOVE_BIT]), .wrIntrClr(regWrData[INTR_BIT]),
    .stepTick(stepTick), .syncPulse(syncPulse), .todValid(todValid),
    .todErr(todErr), .stateQ(stateQ), .loadCmdQ(loadCmdQ),
    .moveCmdQ(moveCmdQ), .intrQ(intrQ), .timeoutQ(timeoutQ),
    .strobe(strobe)
  );

  timebase_loader_dp #(.TB_W(TB_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .cfgIn(regWrData[CFG_W-1:0]), .strobe(strobe), .todValue(todValue),
    .cfgQ(cfgQ), .stepTick(stepTick), .timebase(timebase)
  );

  always_comb begin
    regRdData                   = '0;
    regRdData[CFG_W-1:0]        = cfgQ;
    regRdData[LOAD_BIT]         = loadCmdQ;
    regRdData[MOVE_BIT]         = moveCmdQ;
    regRdData[INTR_BIT]         = intrQ;
    regRdData[TOUT_BIT]         = timeoutQ;
    regRdData[ST_LSB +: ST_W]   = stateQ;
  end

endmodule

// File: rtl/timebase_loader_chk.sv
module timebase_loader_chk
  import timebase_loader_pkg::*;
#(
  parameter int TB_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic             syncPulse,
  input logic             todValid,
  input logic [TB_W-1:0]  todValue,
  input logic [REG_W-1:0] regRdData,
  input logic [TB_W-1:0]  timebase
);

  logic [ST_W-1:0] st;
  logic            abortWr;
  assign st      = regRdData[ST_LSB +: ST_W];
  assign abortWr = regWrEn && !regWrData[EN_BIT];

  p_state_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st != 3'd5) && (st != 3'd6));

  p_load_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RESET && regRdData[LOAD_BIT] && !regWrEn) |=>
      ((st == ST_RESET && regRdData[LOAD_BIT]) ||
       ((st == ST_NOT_SET || st == ST_ERROR) && !regRdData[LOAD_BIT])));

  p_timeout_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[TOUT_BIT]) |-> (st == ST_ERROR));

  p_move_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_NOT_SET && regRdData[INTR_BIT] && regWrEn && regWrData[EN_BIT])
      |=> (st == ST_NOT_SET));

  p_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SYNC_WAIT && syncPulse && !abortWr) |=> (st == ST_GET_TOD));

  p_tod_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_GET_TOD && todValid && !abortWr) |=>
      (timebase == $past(todValue) && st == ST_RUNNING && !regRdData[MOVE_BIT]));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_RUNNING && st != ST_GET_TOD) |=> $stable(timebase));

  p_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUNNING) |=>
      (timebase == $past(timebase) || timebase == $past(timebase) + TB_W'(1)));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    abortWr |=> (st == ST_RESET && !regRdData[LOAD_BIT] &&
                 !regRdData[MOVE_BIT] && !regRdData[TOUT_BIT]));

endmodule

bind timebase_loader timebase_loader_chk #(.TB_W(TB_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .syncPulse(syncPulse), .todValid(todValid), .todValue(todValue),
  .regRdData(regRdData), .timebase(timebase)
);

// File: tb/timebase_loader_tb.sv
module timebase_loader_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        syncPulse = 1'b0;
  logic        todValid = 1'b0;
  logic [63:0] todValue = '0;
  logic        todErr = 1'b0;
  logic [63:0] timebase;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  timebase_loader u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .syncPulse(syncPulse), .todValid(todValid),
    .todValue(todValue), .todErr(todErr), .timebase(timebase)
  );

  localparam logic [63:0] EN   = 64'd1 << 15;
  localparam logic [63:0] LOAD = 64'd1 << 16;
  localparam logic [63:0] MOVE = 64'd1 << 18;
  localparam logic [63:0] INTR = 64'd1 << 51;

  function automatic logic [63:0] cfg(input int n);
    return EN | (64'(n & 15) << 4);
  endfunction

  function automatic logic [63:0] st();
    return 64'(regRdData[62:60]);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [63:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync();
    syncPulse = 1'b1; @(negedge clk); syncPulse = 1'b0;
  endtask

  task automatic xfer(input logic [63:0] v);
    todValid = 1'b1; todValue = v; @(negedge clk); todValid = 1'b0; todValue = '0;
  endtask

  task automatic runToRunning(input int k, input logic [63:0] v);
    wr(64'd0);
    wr(cfg(k) | LOAD);
    wait_n(10);
    wr(cfg(k) | MOVE);
    sync();
    xfer(v);
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    wait_n(4);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reg", regRdData, 64'd0);
    check("R1 timebase", timebase, 64'd0);

    // R2 config storage, reserved bits dropped
    wr(64'h7A5C);
    check("R2 cfg masked", 64'(regRdData[15:0]), 64'h0A5C);
    check("R2 state", st(), 64'd0);
    wr(64'h8A53);
    check("R2 cfg", 64'(regRdData[15:0]), 64'h8A53);

    // R10 move in reset ignored
    wr(cfg(3) | MOVE);
    check("R10 move in reset state", st(), 64'd0);
    check("R10 move bit", 64'(regRdData[18]), 64'd0);

    // R3 exact load timing N=5
    wr(64'd0);
    wr(cfg(5) | LOAD);
    check("R3 pending bit", 64'(regRdData[16]), 64'd1);
    wait_n(4);
    check("R3 before Nth edge", st(), 64'd0);
    wait_n(1);
    check("R3 not-set", st(), 64'd1);
    check("R3 bit16 cleared", 64'(regRdData[16]), 64'd0);

    // R4 exact timeout timing N=12
    wr(64'd0);
    wr(cfg(12) | LOAD);
    wait_n(7);
    check("R4 before timeout", st(), 64'd0);
    wait_n(1);
    check("R4 error", st(), 64'd7);

    // R3/R4 sweep over all clocks-per-step codes
    for (int k = 0; k < 16; k++) begin
      int n;
      n = (k == 0) ? 1 : k;
      wr(64'd0);
      wr(cfg(k) | LOAD);
      wait_n(20);
      check(n <= 8 ? "R3 sweep state" : "R4 sweep state", st(), n <= 8 ? 64'd1 : 64'd7);
      check("R4 sweep timeout bit", 64'(regRdData[54]), n <= 8 ? 64'd0 : 64'd1);
      check("R3 sweep bit16", 64'(regRdData[16]), 64'd0);
    end

    // R9 abort from error
    wr(64'd0);
    check("R9 abort state", st(), 64'd0);
    check("R9 abort timeout bit", 64'(regRdData[54]), 64'd0);

    // R5 interrupt gate, R6/R7 ignore rules
    wr(cfg(2) | LOAD);
    wait_n(5);
    check("R3 n2 not-set", st(), 64'd1);
    todErr = 1'b1; @(negedge clk); todErr = 1'b0;
    check("R5 intr set", 64'(regRdData[51]), 64'd1);
    wr(cfg(2) | MOVE);
    check("R5 move blocked", st(), 64'd1);
    check("R5 move bit", 64'(regRdData[18]), 64'd0);
    sync();
    check("R6 sync ignored in not-set", st(), 64'd1);
    wr(cfg(2) | INTR);
    check("R5 intr cleared", 64'(regRdData[51]), 64'd0);
    wr(cfg(2) | MOVE);
    check("R6 sync-wait", st(), 64'd2);
    check("R6 move bit", 64'(regRdData[18]), 64'd1);
    xfer(64'hDEAD);
    check("R7 xfer ignored state", st(), 64'd2);
    check("R7 xfer ignored timebase", timebase, 64'd0);
    sync();
    check("R6 get-tod", st(), 64'd3);
    xfer(64'h0123_4567_89AB_CDEF);
    check("R7 running", st(), 64'd4);
    check("R7 loaded", timebase, 64'h0123_4567_89AB_CDEF);
    check("R7 move bit cleared", 64'(regRdData[18]), 64'd0);
    wait_n(24);
    check("R8 count n2", timebase, 64'h0123_4567_89AB_CDEF + 64'd12);
    wr(cfg(2) | LOAD);
    check("R10 load in running", st(), 64'd4);
    check("R10 load bit", 64'(regRdData[16]), 64'd0);
    wr(64'd0);
    check("R9 abort from running", st(), 64'd0);
    begin
      logic [63:0] held;
      held = timebase;
      wait_n(10);
      check("R8 hold outside running", timebase, held);
    end

    // R8 sweep of step period
    for (int n = 1; n <= 6; n++) begin
      logic [63:0] v;
      v = 64'h1111_0000_0000_0000 * 64'(n) + 64'(n);
      runToRunning(n, v);
      check("R7 sweep load", timebase, v);
      wait_n(12 * n);
      check("R8 sweep count", timebase, v + 64'd12);
    end

    // R8 wrap
    runToRunning(1, '1);
    check("R8 all ones", timebase, '1);
    wait_n(1);
    check("R8 wrap", timebase, 64'd0);

    finishRun();
  end

endmodule